// File: doc/BRIEF.md
# Serial Port Register File with Status Flags

This block is the register file of an asynchronous serial port that has a receive FIFO. A host reaches it over a simple synchronous register bus: an address, a write strobe, a read strobe, write data and registered read data. It holds the port's setup registers: character mode, bit rate, control, FIFO control and the port-pin register. It keeps the five status flags: transmit-end, transmit-empty, break, receive-full and data-ready. It drives the transmit and receive interrupt lines.

A write to the transmit-data offset hands the byte to the shifter through a one-cycle strobe. The receive FIFO sits in a neighbouring block. Towards that block the register file sends a clear pulse, the trigger-level select and a pop strobe. It takes back the FIFO head byte, the fill level, and pulses that set or clear the receive-side flags. Status flags are cleared by writing 0 to their bit. Reading the status word while the transmitter is enabled re-arms the transmit flags.

Top module: `sercfg_regs`

## Requirements
- R1: After reset the bit-rate register is 0xFF, control is 0x20, and mode, FIFO control and port are 0x00. The status word reads 0x60, and `tx_irq`, `rx_irq`, `tx_strobe` and `fifo_clear` are low.
- R2: Each register applies its own write mask when written: mode (0x00) with 0x7B, control (0x08) with 0xFA, port (0x20) with 0xF3. Bit rate (0x04) and FIFO control (0x18) store all 8 bits. Reading a register returns its stored value.
- R3: The status word at 0x10 places transmit-end at bit 6, transmit-empty at bit 5, break at bit 4, receive-full at bit 1 and data-ready at bit 0, and reads 0 in bits 7, 3 and 2. A `rxf_set`, `dr_set` or `brk_set` pulse sets receive-full, data-ready or break for the next cycle. A `rxf_clr` pulse clears receive-full.
- R4: A status write clears every flag whose bit is written 0 and leaves every flag whose bit is written 1 unchanged. A set pulse in the same cycle wins over the clear.
- R5: A status read returns the flags as they were before the read. If control bit 5 is 1, transmit-empty and transmit-end are then set.
- R6: A control write with bit 5 at 0 sets transmit-end.
- R7: A write to 0x0C raises `tx_strobe` for exactly the next cycle, with `tx_byte` equal to the written data, and clears transmit-empty.
- R8: `tx_irq` equals control bit 7.
- R9: `rx_irq` goes high the cycle after a `rxf_set` pulse while control bit 6 is 1. It goes low after a control write with bit 6 at 0, or after a status write with bit 1 or bit 0 at 0. A set in the same cycle wins.
- R10: A read of 0x14 raises `fifo_pop` combinationally in the same cycle and returns `fifo_rdata` as sampled in that cycle. A read of 0x1C returns `fifo_level`, zero-extended.
- R11: `trig_sel` equals FIFO-control bits 7:6. A FIFO-control write with bit 1 set gives a one-cycle `fifo_clear` pulse in the next cycle.
- R12: Writes to 0x24 (line status) and to unmapped offsets change nothing. Reads of them return 0.
- R13: Read data appears on `bus_rdata` one cycle after the read strobe and is 0 in every other cycle. A cycle with both strobes high is taken as a write only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tx_strobe | output | 1 | One-cycle pulse per transmitted byte |
| tx_byte | output | 8 | Byte handed to the shifter |
| tx_irq | output | 1 | Transmit interrupt level |
| rx_irq | output | 1 | Receive interrupt level |
| fifo_clear | output | 1 | Receive FIFO clear pulse |
| trig_sel | output | 2 | Receive trigger-level select |
| fifo_pop | output | 1 | Pop strobe to the receive FIFO |
| fifo_rdata | input | 8 | Head byte of the receive FIFO |
| fifo_level | input | CNT_W | Receive FIFO fill level |
| rxf_set | input | 1 | Set receive-full (level reached the trigger) |
| rxf_clr | input | 1 | Clear receive-full (level fell below the trigger) |
| dr_set | input | 1 | Set data-ready (receive timeout) |
| brk_set | input | 1 | Set break (break detected) |

## Verification
The bench writes all-ones and random patterns into each register to catch a wrong or shared mask. A mask error shows up as a readback with an extra or missing bit. It writes the status word with single-zero patterns while set pulses arrive in the same cycle. A design with the clear polarity inverted, or with the clear winning over the set, loses or keeps the wrong flag. It reads the status word with the transmitter on and off and checks both that read and the one after it. A design that re-arms before sampling returns 0x60 too early, and one that ignores the enable re-arms when it should not. It also checks that the receive interrupt drops for each of the three clear conditions. Alongside, it checks that line-status and unmapped accesses leave every register and flag unchanged.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

  localparam int DATA_W = 8;

  // register offsets (byte addresses)
  localparam int OFF_MODE = 'h00;
  localparam int OFF_RATE = 'h04;
  localparam int OFF_CTRL = 'h08;
  localparam int OFF_TXD  = 'h0C;
  localparam int OFF_STAT = 'h10;
  localparam int OFF_RXD  = 'h14;
  localparam int OFF_FCTL = 'h18;
  localparam int OFF_RCNT = 'h1C;
  localparam int OFF_PORT = 'h20;
  localparam int OFF_LSR  = 'h24;

  // plain storage registers, indexed by the low values of sel_e
  localparam int NREG = 5;
  localparam logic [DATA_W-1:0] REG_MASK  [NREG] = '{8'h7B, 8'hFF, 8'hFA, 8'hFF, 8'hF3};
  localparam logic [DATA_W-1:0] REG_RESET [NREG] = '{8'h00, 8'hFF, 8'h20, 8'h00, 8'h00};

  // control bits with behaviour attached
  localparam int CTL_TXIE = 7;
  localparam int CTL_RXIE = 6;
  localparam int CTL_TXEN = 5;

  // FIFO-control bits
  localparam int FC_CLR  = 1;
  localparam int FC_TRGL = 6;

  // status bit positions
  localparam int ST_TEND = 6;
  localparam int ST_TDE  = 5;
  localparam int ST_BRK  = 4;
  localparam int ST_RXF  = 1;
  localparam int ST_DRDY = 0;

  typedef enum logic [3:0] {
    SEL_MODE = 4'd0,
    SEL_RATE = 4'd1,
    SEL_CTRL = 4'd2,
    SEL_FCTL = 4'd3,
    SEL_PORT = 4'd4,
    SEL_TXD  = 4'd5,
    SEL_STAT = 4'd6,
    SEL_RXD  = 4'd7,
    SEL_RCNT = 4'd8,
    SEL_LSR  = 4'd9,
    SEL_NONE = 4'd15
  } sel_e;

  typedef struct packed {
    logic tend;
    logic tde;
    logic brk;
    logic rxf;
    logic drdy;
  } flags_t;

endpackage

// File: rtl/sercfg_decode.sv
module sercfg_decode
  import sercfg_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel
);

  always_comb begin
    case (addr)
      ADDR_W'(OFF_MODE): sel = SEL_MODE;
      ADDR_W'(OFF_RATE): sel = SEL_RATE;
      ADDR_W'(OFF_CTRL): sel = SEL_CTRL;
      ADDR_W'(OFF_TXD):  sel = SEL_TXD;
      ADDR_W'(OFF_STAT): sel = SEL_STAT;
      ADDR_W'(OFF_RXD):  sel = SEL_RXD;
      ADDR_W'(OFF_FCTL): sel = SEL_FCTL;
      ADDR_W'(OFF_RCNT): sel = SEL_RCNT;
      ADDR_W'(OFF_PORT): sel = SEL_PORT;
      ADDR_W'(OFF_LSR):  sel = SEL_LSR;
      default:           sel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/sercfg_store.sv
module sercfg_store
  import sercfg_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  sel_e                          sel,
  input  logic [DATA_W-1:0]             wdata,
  output logic [NREG-1:0][DATA_W-1:0]   regs,
  output logic                          tx_strobe,
  output logic [DATA_W-1:0]             tx_byte,
  output logic                          fifo_clear
);

  // one masked storage register per entry of the package tables
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic hit;
    assign hit = wr_en && (sel == sel_e'(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[i] <= REG_RESET[i];
      end else if (hit) begin
        regs[i] <= wdata & REG_MASK[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_strobe  <= 1'b0;
      tx_byte    <= '0;
      fifo_clear <= 1'b0;
    end else begin
      tx_strobe  <= wr_en && (sel == SEL_TXD);
      fifo_clear <= wr_en && (sel == SEL_FCTL) && wdata[FC_CLR];
      if (wr_en && (sel == SEL_TXD)) begin
        tx_byte <= wdata;
      end
    end
  end

endmodule

// File: rtl/sercfg_status.sv
module sercfg_status
  import sercfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  sel_e              sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ctrl_q,
  input  logic              rxf_set,
  input  logic              rxf_clr,
  input  logic              dr_set,
  input  logic              brk_set,
  output flags_t            flags,
  output logic              rx_irq
);

  flags_t flags_d;
  logic   irq_d;

  always_comb begin
    flags_d = flags;
    // clears from the bus and the FIFO first
    if (wr_en && sel == SEL_STAT) begin
      flags_d.tend = flags.tend & wdata[ST_TEND];
      flags_d.tde  = flags.tde  & wdata[ST_TDE];
      flags_d.brk  = flags.brk  & wdata[ST_BRK];
      flags_d.rxf  = flags.rxf  & wdata[ST_RXF];
      flags_d.drdy = flags.drdy & wdata[ST_DRDY];
    end
    if (wr_en && sel == SEL_TXD) begin
      flags_d.tde = 1'b0;
    end
    if (rxf_clr) begin
      flags_d.rxf = 1'b0;
    end
    // then the sets
    if (wr_en && sel == SEL_CTRL && !wdata[CTL_TXEN]) begin
      flags_d.tend = 1'b1;
    end
    if (rd_en && sel == SEL_STAT && ctrl_q[CTL_TXEN]) begin
      flags_d.tend = 1'b1;
      flags_d.tde  = 1'b1;
    end
    if (rxf_set) flags_d.rxf  = 1'b1;
    if (dr_set)  flags_d.drdy = 1'b1;
    if (brk_set) flags_d.brk  = 1'b1;
  end

  always_comb begin
    irq_d = rx_irq;
    if (wr_en && sel == SEL_CTRL && !wdata[CTL_RXIE]) begin
      irq_d = 1'b0;
    end
    if (wr_en && sel == SEL_STAT && !(wdata[ST_RXF] && wdata[ST_DRDY])) begin
      irq_d = 1'b0;
    end
    if (rxf_set && ctrl_q[CTL_RXIE]) begin
      irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags  <= '{tend: 1'b1, tde: 1'b1, brk: 1'b0, rxf: 1'b0, drdy: 1'b0};
      rx_irq <= 1'b0;
    end else begin
      flags  <= flags_d;
      rx_irq <= irq_d;
    end
  end

endmodule

// File: rtl/sercfg_rdmux.sv
module sercfg_rdmux
  import sercfg_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rd_en,
  input  sel_e                        sel,
  input  logic [NREG-1:0][DATA_W-1:0] regs,
  input  flags_t                      flags,
  input  logic [DATA_W-1:0]           fifo_rdata,
  input  logic [CNT_W-1:0]            fifo_level,
  output logic [DATA_W-1:0]           rdata
);

  logic [DATA_W-1:0] status_word;
  logic [DATA_W-1:0] rd_val;

  always_comb begin
    status_word          = '0;
    status_word[ST_TEND] = flags.tend;
    status_word[ST_TDE]  = flags.tde;
    status_word[ST_BRK]  = flags.brk;
    status_word[ST_RXF]  = flags.rxf;
    status_word[ST_DRDY] = flags.drdy;
  end

  always_comb begin
    case (sel)
      SEL_MODE, SEL_RATE, SEL_CTRL, SEL_FCTL, SEL_PORT:
        rd_val = regs[int'(sel)];
      SEL_STAT: rd_val = status_word;
      SEL_RXD:  rd_val = fifo_rdata;
      SEL_RCNT: rd_val = DATA_W'(fifo_level);
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= rd_en ? rd_val : '0;
    end
  end

endmodule

// File: rtl/sercfg_regs.sv
module sercfg_regs
  import sercfg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              tx_strobe,
  output logic [7:0]        tx_byte,
  output logic              tx_irq,
  output logic              rx_irq,
  output logic              fifo_clear,
  output logic [1:0]        trig_sel,
  output logic              fifo_pop,
  input  logic [7:0]        fifo_rdata,
  input  logic [CNT_W-1:0]  fifo_level,
  input  logic              rxf_set,
  input  logic              rxf_clr,
  input  logic              dr_set,
  input  logic              brk_set
);

  sel_e                        sel;
  logic                        rd_en;
  logic [NREG-1:0][DATA_W-1:0] regs;
  flags_t                      flags;

  // a write takes the cycle when both strobes are high
  assign rd_en = bus_rd && !bus_wr;

  sercfg_decode #(.ADDR_W(ADDR_W)) dec_i (
    .addr (bus_addr),
    .sel  (sel)
  );

  sercfg_store store_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (bus_wr),
    .sel        (sel),
    .wdata      (bus_wdata),
    .regs       (regs),
    .tx_strobe  (tx_strobe),
    .tx_byte    (tx_byte),
    .fifo_clear (fifo_clear)
  );

  sercfg_status status_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bus_wr),
    .rd_en   (rd_en),
    .sel     (sel),
    .wdata   (bus_wdata),
    .ctrl_q  (regs[int'(SEL_CTRL)]),
    .rxf_set (rxf_set),
    .rxf_clr (rxf_clr),
    .dr_set  (dr_set),
    .brk_set (brk_set),
    .flags   (flags),
    .rx_irq  (rx_irq)
  );

  sercfg_rdmux #(.CNT_W(CNT_W)) rdmux_i (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .sel        (sel),
    .regs       (regs),
    .flags      (flags),
    .fifo_rdata (fifo_rdata),
    .fifo_level (fifo_level),
    .rdata      (bus_rdata)
  );

  assign tx_irq   = regs[int'(SEL_CTRL)][CTL_TXIE];
  assign trig_sel = regs[int'(SEL_FCTL)][FC_TRGL+1:FC_TRGL];
  assign fifo_pop = rd_en && (sel == SEL_RXD);

endmodule

// File: rtl/sercfg_regs_chk.sv
module sercfg_regs_chk #(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              tx_strobe,
  input logic [7:0]        tx_byte,
  input logic              tx_irq,
  input logic              rx_irq,
  input logic              fifo_clear,
  input logic              fifo_pop,
  input logic              rxf_set
);

  logic a_ctl, a_txd, a_fc, a_lsr, a_rxd;
  assign a_ctl = bus_wr && bus_addr == ADDR_W'('h08);
  assign a_txd = bus_wr && bus_addr == ADDR_W'('h0C);
  assign a_fc  = bus_wr && bus_addr == ADDR_W'('h18);
  assign a_lsr = bus_rd && !bus_wr && bus_addr == ADDR_W'('h24);
  assign a_rxd = bus_rd && !bus_wr && bus_addr == ADDR_W'('h14);

  // R7: byte strobe follows a transmit-data write
  a_r7_strobe: assert property (@(posedge clk) disable iff (rst)
    a_txd |=> tx_strobe && tx_byte == $past(bus_wdata));

  a_r7_no_strobe: assert property (@(posedge clk) disable iff (rst)
    !a_txd |=> !tx_strobe);

  // R8: transmit interrupt level tracks the written control bit
  a_r8_txirq: assert property (@(posedge clk) disable iff (rst)
    a_ctl |=> tx_irq == $past(bus_wdata[7]));

  // R9: control write with receive-interrupt enable low drops the line
  a_r9_rxirq_off: assert property (@(posedge clk) disable iff (rst)
    a_ctl && !bus_wdata[6] && !rxf_set |=> !rx_irq);

  // R10: pop only during a read
  a_r10_pop: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> a_rxd);

  // R11: clear pulse after a FIFO-control write with the clear bit
  a_r11_fifo_clear: assert property (@(posedge clk) disable iff (rst)
    a_fc && bus_wdata[1] |=> fifo_clear);

  // R12: line status reads as zero
  a_r12_lsr_zero: assert property (@(posedge clk) disable iff (rst)
    a_lsr |=> bus_rdata == 8'h00);

  // R13: no read, no data
  a_r13_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && !bus_wr) |=> bus_rdata == 8'h00);

endmodule

bind sercfg_regs sercfg_regs_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .tx_strobe  (tx_strobe),
  .tx_byte    (tx_byte),
  .tx_irq     (tx_irq),
  .rx_irq     (rx_irq),
  .fifo_clear (fifo_clear),
  .fifo_pop   (fifo_pop),
  .rxf_set    (rxf_set)
);

// File: tb/sercfg_regs_tb_top.sv
module sercfg_regs_tb_top;

  localparam int ADDR_W = 6;
  localparam int CNT_W  = 5;

  logic              clk = 1'b0;
  logic              rst;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_wr, bus_rd;
  logic [7:0]        bus_wdata, bus_rdata;
  logic              tx_strobe, tx_irq, rx_irq, fifo_clear, fifo_pop;
  logic [7:0]        tx_byte, fifo_rdata;
  logic [1:0]        trig_sel;
  logic [CNT_W-1:0]  fifo_level;
  logic              rxf_set, rxf_clr, dr_set, brk_set;

  always #4 clk = ~clk;

  sercfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (.*);

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  // reference state
  logic [7:0] m_mode, m_rate, m_ctrl, m_fctl, m_port;
  logic       m_tend, m_tde, m_brk, m_rxf, m_drdy, m_rxirq;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] status_word();
    return {1'b0, m_tend, m_tde, m_brk, 2'b00, m_rxf, m_drdy};
  endfunction

  function automatic logic [7:0] model_read(input logic [5:0] a);
    case (a)
      6'h00: return m_mode;
      6'h04: return m_rate;
      6'h08: return m_ctrl;
      6'h10: return status_word();
      6'h14: return fifo_rdata;
      6'h18: return m_fctl;
      6'h1C: return 8'(fifo_level);
      6'h20: return m_port;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string read_tag(input logic [5:0] a);
    case (a)
      6'h10: return "R3/R5 status";
      6'h14, 6'h1C: return "R10 fifo read";
      6'h24: return "R12 line status";
      6'h00, 6'h04, 6'h08, 6'h18, 6'h20: return "R2 register";
      default: return "R12 unmapped";
    endcase
  endfunction

  task automatic model_reset();
    m_mode = 8'h00; m_rate = 8'hFF; m_ctrl = 8'h20; m_fctl = 8'h00; m_port = 8'h00;
    m_tend = 1'b1; m_tde = 1'b1; m_brk = 1'b0; m_rxf = 1'b0; m_drdy = 1'b0;
    m_rxirq = 1'b0;
  endtask

  // one bus cycle: drive, predict, check after the edge
  task automatic step(input bit wr, input bit rd, input logic [5:0] a, input logic [7:0] d,
                      input bit e_rs, input bit e_rc, input bit e_dr, input bit e_bk);
    bit         rd_eff;
    logic [7:0] exp_rd, old_ctrl;
    bit         exp_stb, exp_clr;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    rxf_set = e_rs; rxf_clr = e_rc; dr_set = e_dr; brk_set = e_bk;
    fifo_rdata = 8'($urandom); fifo_level = CNT_W'($urandom_range(0, 16));
    #1;
    rd_eff = rd && !wr;
    chk(8'(fifo_pop), 8'(rd_eff && a == 6'h14), "R10 pop");
    exp_rd  = rd_eff ? model_read(a) : 8'h00;
    exp_stb = wr && a == 6'h0C;
    exp_clr = wr && a == 6'h18 && d[1];
    old_ctrl = m_ctrl;
    // clears
    if (wr) begin
      case (a)
        6'h00: m_mode = d & 8'h7B;
        6'h04: m_rate = d;
        6'h08: begin
          m_ctrl = d & 8'hFA;
          if (!d[5]) m_tend = 1'b1;
          if (!d[6]) m_rxirq = 1'b0;
        end
        6'h0C: m_tde = 1'b0;
        6'h10: begin
          m_tend &= d[6]; m_tde &= d[5]; m_brk &= d[4]; m_rxf &= d[1]; m_drdy &= d[0];
          if (!d[1] || !d[0]) m_rxirq = 1'b0;
        end
        6'h18: m_fctl = d;
        6'h20: m_port = d & 8'hF3;
        default: ;
      endcase
    end
    if (e_rc) m_rxf = 1'b0;
    if (rd_eff && a == 6'h10 && old_ctrl[5]) begin
      m_tend = 1'b1; m_tde = 1'b1;
    end
    if (e_rs) m_rxf = 1'b1;
    if (e_dr) m_drdy = 1'b1;
    if (e_bk) m_brk = 1'b1;
    if (e_rs && old_ctrl[6]) m_rxirq = 1'b1;
    @(posedge clk);
    #2;
    chk(bus_rdata, exp_rd, rd_eff ? read_tag(a) : "R13 idle data");
    chk(8'(tx_strobe), 8'(exp_stb), "R7 strobe");
    if (exp_stb) chk(tx_byte, d, "R7 byte");
    chk(8'(tx_irq), 8'(m_ctrl[7]), "R8 tx_irq");
    chk(8'(rx_irq), 8'(m_rxirq), "R9 rx_irq");
    chk(8'(trig_sel), 8'(m_fctl[7:6]), "R11 trig_sel");
    chk(8'(fifo_clear), 8'(exp_clr), "R11 fifo_clear");
  endtask

  task automatic wr_op(input logic [5:0] a, input logic [7:0] d);
    step(1, 0, a, d, 0, 0, 0, 0);
  endtask

  task automatic rd_op(input logic [5:0] a);
    step(0, 1, a, 8'h00, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [5:0] addrs [14] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h18,
                               6'h1C, 6'h20, 6'h24, 6'h02, 6'h28, 6'h30, 6'h3F};
    void'($urandom(32'h5EED_0C2A));
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    rxf_set = 0; rxf_clr = 0; dr_set = 0; brk_set = 0;
    fifo_rdata = '0; fifo_level = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state at the ports and through reads
    chk(8'(tx_irq), 8'h00, "R1 tx_irq");
    chk(8'(rx_irq), 8'h00, "R1 rx_irq");
    chk(8'(tx_strobe), 8'h00, "R1 tx_strobe");
    chk(8'(fifo_clear), 8'h00, "R1 fifo_clear");
    step(0, 1, 6'h04, 0, 0, 0, 0, 0);  // R1 rate 0xFF
    step(0, 1, 6'h08, 0, 0, 0, 0, 0);  // R1 ctrl 0x20
    step(0, 1, 6'h00, 0, 0, 0, 0, 0);  // R1 mode
    step(0, 1, 6'h18, 0, 0, 0, 0, 0);  // R1 fifo control
    step(0, 1, 6'h20, 0, 0, 0, 0, 0);  // R1 port
    // R5: status read 0x60 with transmitter enabled
    rd_op(6'h10);
    // R2: masks with all ones
    foreach (addrs[i]) if (addrs[i] != 6'h10 && addrs[i] != 6'h0C) wr_op(addrs[i], 8'hFF);
    foreach (addrs[i]) if (addrs[i] != 6'h14) rd_op(addrs[i]);
    // R3/R4: set all flags, clear one at a time, with a set colliding
    step(0, 0, 6'h00, 0, 1, 0, 1, 1);
    wr_op(6'h10, 8'hEF);               // R4 clear break only
    rd_op(6'h10);
    step(1, 0, 6'h10, 8'h00, 1, 0, 0, 0); // R4 set wins over clear
    rd_op(6'h10);
    // R6/R5: transmitter off, write then read twice
    wr_op(6'h08, 8'h40);
    wr_op(6'h10, 8'h00);
    wr_op(6'h08, 8'h00);               // R6 sets transmit-end
    rd_op(6'h10);
    rd_op(6'h10);                      // R5 no re-arm with enable low
    wr_op(6'h0C, 8'hA5);               // R7
    wr_op(6'h08, 8'h20);
    rd_op(6'h10);                      // R5 returns old flags
    rd_op(6'h10);                      // R5 then re-armed
    // R9: the three receive-interrupt clears
    wr_op(6'h08, 8'hE0);
    step(0, 0, 6'h00, 0, 1, 0, 0, 0);
    wr_op(6'h10, 8'hFE);
    step(0, 0, 6'h00, 0, 1, 0, 0, 0);
    wr_op(6'h10, 8'hFD);
    step(0, 0, 6'h00, 0, 1, 0, 0, 0);
    wr_op(6'h08, 8'h20);
    // R10/R11
    rd_op(6'h14); rd_op(6'h1C);
    step(0, 0, 6'h00, 0, 0, 1, 0, 0);
    wr_op(6'h18, 8'hC2); wr_op(6'h18, 8'h40);
    // R12: ignored writes leave state alone
    wr_op(6'h24, 8'h00); wr_op(6'h28, 8'h00); rd_op(6'h10); rd_op(6'h24);
    // R13: both strobes
    step(1, 1, 6'h04, 8'h3C, 0, 0, 0, 0);
    rd_op(6'h04);
    // constrained random
    for (int k = 0; k < 6000; k++) begin
      int  r  = $urandom_range(0, 99);
      bit  wr = r < 45;
      bit  rd = (r >= 45 && r < 90) || (r == 99);
      step(wr, rd, addrs[$urandom_range(0, 13)], 8'($urandom),
           $urandom_range(0, 11) == 0, $urandom_range(0, 11) == 0,
           $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0);
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule